// File: doc/BRIEF.md
# Pipelined Population Counter

This block counts the one bits of a WIDTH-bit input vector and returns the total on a 32-bit output. Inside, a binary tree of adders reduces the vector. Level k of the tree adds pairs of k-bit operands into (k+1)-bit sums, and the tree ends when a single operand is left. A level with an odd operand count passes its lowest operand on unchanged, widened by one zero bit. The remaining operands then pair up one index higher.

The total latency is a parameter, LATENCY, in clock cycles. Pipeline registers are spread across the tree levels as evenly as the depth allows. Any remainder goes to the earliest boundaries. Latency beyond one register per level is stacked as delay stages after the final sum. The output register always closes the pipeline.

A valid flag travels with each vector, so a new vector can enter on every cycle. Each pipeline stage loads only when the data entering it is marked valid. This means the output holds its last result between valid items.

Top module: `popcount_pipe`

## Requirements
- R1: When outValid is high, countOut[31:0] holds the number of one bits in the vector that the block accepted; all bits above the count's width read zero.
- R2: A vector accepted at a rising edge (inValid high) yields its result exactly LATENCY rising edges later. This holds for every LATENCY of at least 1, including values larger than the tree depth plus one.
- R3: A vector may be accepted on every clock cycle. Back-to-back vectors each produce their own result, in acceptance order, and none is lost.
- R4: outValid is high in exactly those cycles in which a result is due, that is inValid delayed by LATENCY cycles.
- R5: rstN is synchronous and active low. While it is low, outValid is low and inValid is ignored. After rstN is released, outValid stays low until the first accepted vector reaches the output.
- R6: countOut changes only in cycles where outValid is high. Vectors presented with inValid low leave countOut unchanged.
- R7: The count is correct for every WIDTH of at least 2, including odd widths and widths that are not a power of two. An all-zero vector gives 0 and an all-one vector gives WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset of the valid pipeline |
| inValid | input | 1 | Marks dataIn as a vector to be counted |
| dataIn | input | WIDTH | Vector whose one bits are counted |
| countOut | output | 32 | Registered count, zero-extended |
| outValid | output | 1 | High when countOut carries a new result |

## Verification
Every count is due exactly LATENCY rising edges after the edge that accepts its vector. The driver stamps each expected count with that edge number when it queues it. The monitor samples at falling edges, pops an item whenever outValid is high, and checks both the value and that the current edge number equals the stamp. It also flags any cycle where a stamped item is due but outValid is low, and checks that countOut stays fixed on cycles where outValid is low. Four instances with different widths and latencies run side by side, covering LATENCY of 1, odd widths and latency beyond the tree depth.

// File: rtl/popcount_pkg.sv
package popcount_pkg;

  localparam int CountW = 32;

  // number of halving steps until one operand remains
  function automatic int treeDepth(input int n);
    int m;
    int d;
    m = n;
    d = 0;
    while (m > 1) begin
      m = (m + 1) / 2;
      d++;
    end
    return d;
  endfunction

  // operands present after k levels of the tree
  function automatic int levelCount(input int n, input int k);
    int m;
    m = n;
    for (int j = 0; j < k; j++) m = (m + 1) / 2;
    return m;
  endfunction

  // internal register boundaries placed right after level k:
  // each boundary advances by depth/lat levels, the first depth%lat ones by one extra
  function automatic int regsAfter(input int depth, input int lat, input int k);
    int step;
    int extra;
    int pos;
    int hits;
    step  = depth / lat;
    extra = depth % lat;
    pos   = 0;
    hits  = 0;
    for (int j = 0; j < lat - 1; j++) begin
      pos += step;
      if (extra > 0) begin
        pos++;
        extra--;
      end
      if (pos == k) hits++;
    end
    return hits;
  endfunction

  // index of the first load enable used by level k
  function automatic int stageBase(input int depth, input int lat, input int k);
    int s;
    s = 0;
    for (int j = 1; j < k; j++) s += regsAfter(depth, lat, j);
    return s;
  endfunction

endpackage

// File: rtl/popcount_pair_add.sv
module popcount_pair_add #(
  parameter int W = 1
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W:0]   sum
);
  assign sum = {1'b0, opA} + {1'b0, opB};
endmodule

// File: rtl/popcount_ctrl.sv
module popcount_ctrl #(
  parameter int LATENCY = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic [LATENCY-1:0] loadEn,
  output logic               outValid
);
  logic               admit;
  logic [LATENCY-1:0] validQ;

  assign admit = inValid & rstN;

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= '0;
    else       validQ <= LATENCY'({validQ, admit});
  end

  // stage j loads when the item entering it is valid
  assign loadEn   = LATENCY'({validQ, admit});
  assign outValid = validQ[LATENCY-1];
endmodule

// File: rtl/popcount_tree.sv
module popcount_tree
  import popcount_pkg::*;
#(
  parameter int WIDTH   = 64,
  parameter int LATENCY = 3
) (
  input  logic               clk,
  input  logic [LATENCY-1:0] loadEn,
  input  logic [WIDTH-1:0]   dataIn,
  output logic [CountW-1:0]  countOut
);
  localparam int Depth = treeDepth(WIDTH);

  for (genvar k = 1; k <= Depth; k++) begin : lvlG
    localparam int InN     = levelCount(WIDTH, k - 1);
    localparam int OutN    = levelCount(WIDTH, k);
    localparam int OddIn   = InN % 2;
    localparam int NumRegs = regsAfter(Depth, LATENCY, k) + ((k == Depth) ? 1 : 0);
    localparam int FirstEn = stageBase(Depth, LATENCY, k);

    logic [InN-1:0][k-1:0] inV;
    logic [OutN-1:0][k:0]  sumV;
    logic [OutN-1:0][k:0]  outV;

    if (k == 1) begin : srcRawG
      assign inV = dataIn;
    end else begin : srcPrevG
      assign inV = lvlG[k-1].outV;
    end

    for (genvar i = 0; i < OutN; i++) begin : pairG
      if (OddIn == 1 && i == 0) begin : passG
        assign sumV[0] = {1'b0, inV[0]};
      end else begin : addG
        localparam int Lo = (OddIn == 1) ? 2 * i - 1 : 2 * i;
        popcount_pair_add #(.W(k)) add_i (
          .opA(inV[Lo+1]),
          .opB(inV[Lo]),
          .sum(sumV[i])
        );
      end
    end

    for (genvar r = 1; r <= NumRegs; r++) begin : regG
      logic [OutN-1:0][k:0] q;
      if (r == 1) begin : headG
        always_ff @(posedge clk) begin
          if (loadEn[FirstEn]) q <= sumV;
        end
      end else begin : tailG
        always_ff @(posedge clk) begin
          if (loadEn[FirstEn+r-1]) q <= regG[r-1].q;
        end
      end
    end

    if (NumRegs == 0) begin : wireG
      assign outV = sumV;
    end else begin : regOutG
      assign outV = regG[NumRegs].q;
    end
  end

  assign countOut = {{(CountW - Depth - 1){1'b0}}, lvlG[Depth].outV};
endmodule

// File: rtl/popcount_pipe.sv
module popcount_pipe #(
  parameter int WIDTH   = 64,
  parameter int LATENCY = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WIDTH-1:0] dataIn,
  output logic [31:0]      countOut,
  output logic             outValid
);
  logic [LATENCY-1:0] loadEn;

  popcount_ctrl #(.LATENCY(LATENCY)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .loadEn  (loadEn),
    .outValid(outValid)
  );

  popcount_tree #(.WIDTH(WIDTH), .LATENCY(LATENCY)) tree_i (
    .clk     (clk),
    .loadEn  (loadEn),
    .dataIn  (dataIn),
    .countOut(countOut)
  );
endmodule

// File: rtl/popcount_pipe_chk.sv
module popcount_pipe_chk #(
  parameter int WIDTH   = 64,
  parameter int LATENCY = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [WIDTH-1:0] dataIn,
  input logic [31:0]      countOut,
  input logic             outValid
);
  logic [31:0]        cntNow;
  logic [31:0]        cntPipe [LATENCY];
  logic [LATENCY-1:0] vldPipe;

  assign cntNow = 32'($countones(dataIn));

  always_ff @(posedge clk) begin
    cntPipe[0] <= cntNow;
    for (int j = 1; j < LATENCY; j++) cntPipe[j] <= cntPipe[j-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) vldPipe <= '0;
    else       vldPipe <= LATENCY'({vldPipe, inValid});
  end

  assert_count_match_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> countOut == cntPipe[LATENCY-1]);

  assert_valid_delay_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid == vldPipe[LATENCY-1]);

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(countOut));

  assert_count_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> countOut <= 32'(WIDTH));
endmodule

bind popcount_pipe popcount_pipe_chk #(.WIDTH(WIDTH), .LATENCY(LATENCY)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .dataIn  (dataIn),
  .countOut(countOut),
  .outValid(outValid)
);

// File: tb/popcount_pipe_tb_top.sv
module popcount_pipe_tb_unit #(
  parameter int N = 8,
  parameter int L = 2
) (
  input  logic clk,
  input  logic rstN,
  output int   checks,
  output int   errors,
  output logic done
);
  logic         inValid;
  logic [N-1:0] dataIn;
  logic [31:0]  countOut;
  logic         outValid;

  popcount_pipe #(.WIDTH(N), .LATENCY(L)) dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .dataIn  (dataIn),
    .countOut(countOut),
    .outValid(outValid)
  );

  int    cyc = 0;
  int    nChecks = 0;
  int    nErrors = 0;
  logic  doneR = 1'b0;
  logic  drvDone = 1'b0;
  int    expQ[$];
  int    cycQ[$];
  string tagQ[$];
  int    lastCount;
  bit    haveLast = 1'b0;

  assign checks = nChecks;
  assign errors = nErrors;
  assign done   = doneR;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int refCount(input logic [N-1:0] v);
    int c;
    c = 0;
    for (int i = 0; i < N; i++) if (v[i]) c++;
    return c;
  endfunction

  function automatic logic [N-1:0] randVec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = 1'($urandom_range(0, 1));
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s N=%0d L=%0d cycle=%0d actual=%0d expected=%0d", tag, N, L, cyc, act, exp);
    end
  endtask

  task automatic drive(input logic vld, input logic [N-1:0] v, input string tag);
    @(negedge clk);
    inValid = vld;
    dataIn  = v;
    if (vld) begin
      expQ.push_back(refCount(v));
      cycQ.push_back(cyc + L);
      tagQ.push_back(tag);
    end
  endtask

  // driver
  initial begin
    logic [N-1:0] alt;
    inValid = 1'b0;
    dataIn  = '0;
    @(posedge rstN);
    drive(1'b0, '0, "");
    drive(1'b0, '1, "");
    drive(1'b1, '0, "R7");
    drive(1'b1, '1, "R7");
    drive(1'b1, N'(1), "R1");
    drive(1'b1, {1'b1, {(N - 1){1'b0}}}, "R1");
    for (int i = 0; i < N; i++) alt[i] = 1'(i % 2);
    drive(1'b1, alt, "R7");
    drive(1'b1, ~alt, "R7");
    for (int i = 0; i < 3; i++) drive(1'b0, randVec(), "");
    for (int i = 0; i < 60; i++) drive(1'b1, randVec(), "R3");
    for (int i = 0; i < 60; i++) drive(1'($urandom_range(0, 1)), randVec(), "R1");
    drive(1'b1, '1, "R7");
    for (int i = 0; i < L + 4; i++) drive(1'b0, randVec(), "");
    drvDone = 1'b1;
  end

  // monitor
  always @(negedge clk) begin
    if (!rstN) begin
      if (cyc >= 1) chk(outValid == 1'b0, "R5", outValid, 0);
    end else begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, haveLast ? "R4" : "R5", 1, 0);
        end else begin
          int    e;
          int    c;
          string t;
          e = expQ.pop_front();
          c = cycQ.pop_front();
          t = tagQ.pop_front();
          chk(cyc == c, "R2", cyc, c);
          chk(countOut == 32'(e), t, countOut, e);
          lastCount = int'(countOut);
          haveLast  = 1'b1;
        end
      end else begin
        if (expQ.size() != 0 && cycQ[0] == cyc) chk(1'b0, "R4", 0, 1);
        if (haveLast) chk(countOut == 32'(lastCount), "R6", countOut, lastCount);
      end
      if (drvDone && !doneR) begin
        chk(expQ.size() == 0, "R3", expQ.size(), 0);
        doneR <= 1'b1;
      end
    end
  end
endmodule

module popcount_pipe_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;

  always #10 clk = ~clk;

  int   cA, eA, cB, eB, cC, eC, cD, eD;
  logic dA, dB, dC, dD;

  popcount_pipe_tb_unit #(.N(64), .L(3)) unitA (.clk(clk), .rstN(rstN), .checks(cA), .errors(eA), .done(dA));
  popcount_pipe_tb_unit #(.N(13), .L(1)) unitB (.clk(clk), .rstN(rstN), .checks(cB), .errors(eB), .done(dB));
  popcount_pipe_tb_unit #(.N(2),  .L(5)) unitC (.clk(clk), .rstN(rstN), .checks(cC), .errors(eC), .done(dC));
  popcount_pipe_tb_unit #(.N(37), .L(4)) unitD (.clk(clk), .rstN(rstN), .checks(cD), .errors(eD), .done(dD));

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  end

  initial begin
    int cycles;
    bit timedOut;
    int totC;
    int totE;
    cycles   = 0;
    timedOut = 1'b0;
    while (!(dA && dB && dC && dD)) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        timedOut = 1'b1;
        break;
      end
    end
    @(negedge clk);
    totC = cA + cB + cC + cD;
    totE = eA + eB + eC + eD;
    if (timedOut) begin
      totC++;
      totE++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
    end
    $display("CHECKS %0d ERRORS %0d", totC, totE);
    $finish;
  end
endmodule